// File: doc/BRIEF.md
# Double-Buffered Serial Port with Register Interface

This block is a byte-wide asynchronous serial port on an APB-style register bus. On the transmit side a one-byte holding stage sits in front of the frame shifter. Software can queue a second byte while the first is still on the line, and two status flags report separately whether the shifter and the holding stage are free. The receive side keeps one byte and raises a data-ready flag when it arrives. It also records an overrun when a new byte lands before software has read the previous one.

Frames are one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A programmable divider produces an oversampling tick, and one bit lasts sixteen ticks. The receiver confirms a start bit at its middle before it accepts a frame, so short low glitches on the line are ignored. A single interrupt output pulses once for every frame sent and for every byte received.

The register offsets are: 0x00 data, 0x04 status, 0x08 control and 0x0C divider. In the status word, bit 0 is data ready, bit 1 is shifter empty, bit 2 is holding empty and bit 4 is overrun. The other bits read 0.

Top module: `uart_hold`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x06, the control register (offset 0x08) reads 0x03, txd is high and irq is low.
- R2: The divider register at offset 0x0C is 16 bits wide, reads back the value written, and sets the bit time to 16*(divider+1) clock cycles.
- R3: A write to the data register (offset 0x00) while the shifter is empty starts a frame with that byte. Status bit 1 then reads 0 and bit 2 stays 1.
- R4: A write to the data register while a frame is in progress stores the byte in the holding stage and clears status bit 2. That byte is sent immediately after the current frame, and bytes leave in the order they were written.
- R5: Each frame on txd is a low start bit, eight data bits sent least significant bit first, and a high stop bit. txd is high when idle.
- R6: When a frame ends with the holding stage empty, status bit 1 is set again, so the idle status reads 0x06. When the holding stage is full, its byte moves to the shifter, bit 2 is set and the next frame begins.
- R7: A received frame sets status bit 0. The receiver accepts a start only if rxd is still low at mid-bit, so a low pulse shorter than half a bit is ignored. A read of the data register returns the byte in bits 7:0 and clears bit 0.
- R8: If a byte arrives while status bit 0 is set and the data register is not being read in that cycle, status bit 4 is set. The data register then holds the newest byte.
- R9: A write to the status register clears bit 4. It leaves bit 0 unchanged. Bits 1 and 2 keep following the state of the transmit path, so a status write has no effect on them.
- R10: irq is a one-cycle pulse, raised in the cycle after each transmit frame ends and in the cycle after each byte is received.
- R11: The control register always reads 0x03, and writes to it are ignored. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt pulse |

## Verification
Some properties are checked on every cycle:
- the holding stage is never full while the shifter is idle;
- every frame end and every received byte is followed by an irq pulse;
- an unread byte followed by a new one always sets overrun;
- a data read clears data ready;
- each new frame starts with a low start bit.

Other behaviour only the bench scenarios can show:
- the bit order and timing on txd;
- the ordering of queued bytes;
- rejection of a glitch on rxd;
- the exact status words after overrun and after a status write;
- the fact that control writes are ignored.

// File: rtl/uart_hold_pkg.sv
package uart_hold_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int OSR        = 16;

  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_DIV  = 8'h0C;

  localparam int ST_DR   = 0;
  localparam int ST_TSRE = 1;
  localparam int ST_THRE = 2;
  localparam int ST_OVR  = 4;

  localparam logic [31:0] CTRL_VALUE = 32'd3;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  function automatic logic [FRAME_BITS-1:0] frame_word(input logic [DATA_BITS-1:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  function automatic logic [31:0] status_word(input logic dr, input logic tsre,
                                              input logic thre, input logic ovr);
    logic [31:0] w;
    w = '0;
    w[ST_DR]   = dr;
    w[ST_TSRE] = tsre;
    w[ST_THRE] = thre;
    w[ST_OVR]  = ovr;
    return w;
  endfunction
endpackage

// File: rtl/uart_hold_baud.sv
module uart_hold_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= div;
    else cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/uart_hold_tx.sv
module uart_hold_tx
  import uart_hold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  output logic                 txd,
  output logic                 busy,
  output logic                 done
);
  localparam int SUB_W = $clog2(OSR);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [SUB_W-1:0]      sub;
  logic [BIT_W-1:0]      bitn;
  logic                  last_tick;

  assign last_tick = busy && tick && (sub == SUB_W'(OSR-1)) && (bitn == BIT_W'(FRAME_BITS-1));
  assign done = last_tick;
  assign txd  = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      sub   <= '0;
      bitn  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= frame_word(data);
      sub   <= '0;
      bitn  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (sub == SUB_W'(OSR-1)) begin
        sub <= '0;
        if (last_tick) busy <= 1'b0;
        else begin
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          bitn  <= bitn + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // R5
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> !txd);
endmodule

// File: rtl/uart_hold_rx.sv
module uart_hold_rx
  import uart_hold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 valid,
  output logic [DATA_BITS-1:0] data
);
  localparam int SUB_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_BITS);

  rx_state_t        st;
  logic [1:0]       sync;
  logic             line;
  logic [SUB_W-1:0] sub;
  logic [BIT_W-1:0] bitn;

  assign line = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      sub   <= '0;
      bitn  <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: if (sub == SUB_W'(OSR/2-1)) begin
            sub  <= '0;
            bitn <= '0;
            st   <= line ? RX_IDLE : RX_DATA;
          end else sub <= sub + 1'b1;
          RX_DATA: if (sub == SUB_W'(OSR-1)) begin
            sub  <= '0;
            data <= {line, data[DATA_BITS-1:1]};
            if (bitn == BIT_W'(DATA_BITS-1)) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else sub <= sub + 1'b1;
          default: if (sub == SUB_W'(OSR-1)) begin
            sub   <= '0;
            st    <= RX_IDLE;
            valid <= line;
          end else sub <= sub + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_hold.sv
module uart_hold
  import uart_hold_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  logic wr, rd, wr_data, wr_stat, wr_div, rd_data;
  logic tick, tx_active, tx_done, tx_load, rx_valid;
  logic [DATA_BITS-1:0] tx_byte, hold, rbuf, rx_byte;
  logic hold_full, dr, ovr;
  logic [DIV_W-1:0] div;
  logic unused_bits;

  assign unused_bits = ^pwdata[31:DIV_W];

  assign wr      = psel && penable && pwrite;
  assign rd      = psel && penable && !pwrite;
  assign wr_data = wr && (paddr == ADDR_W'(OFF_DATA));
  assign wr_stat = wr && (paddr == ADDR_W'(OFF_STAT));
  assign wr_div  = wr && (paddr == ADDR_W'(OFF_DIV));
  assign rd_data = rd && (paddr == ADDR_W'(OFF_DATA));

  uart_hold_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

  uart_hold_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .data(tx_byte),
    .txd(txd), .busy(tx_active), .done(tx_done));

  uart_hold_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .valid(rx_valid), .data(rx_byte));

  always_comb begin
    tx_load = 1'b0;
    tx_byte = hold;
    if (tx_done && hold_full) begin
      tx_load = 1'b1;
    end else if (wr_data && (!tx_active || tx_done)) begin
      tx_load = 1'b1;
      tx_byte = pwdata[DATA_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (tx_done && hold_full) begin
      if (wr_data) hold <= pwdata[DATA_BITS-1:0];
      else hold_full <= 1'b0;
    end else if (wr_data && tx_active && !tx_done) begin
      hold      <= pwdata[DATA_BITS-1:0];
      hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= '0;
      dr   <= 1'b0;
      ovr  <= 1'b0;
      irq  <= 1'b0;
      div  <= DIV_RESET;
    end else begin
      irq <= tx_done || rx_valid;
      if (wr_div) div <= pwdata[DIV_W-1:0];
      if (rx_valid) begin
        rbuf <= rx_byte;
        dr   <= 1'b1;
      end else if (rd_data) begin
        dr <= 1'b0;
      end
      if (wr_stat) ovr <= 1'b0;
      if (rx_valid && dr && !rd_data) ovr <= 1'b1;
    end
  end

  always_comb begin
    case (paddr)
      ADDR_W'(OFF_DATA): prdata = 32'(rbuf);
      ADDR_W'(OFF_STAT): prdata = status_word(dr, !tx_active, !hold_full, ovr);
      ADDR_W'(OFF_CTRL): prdata = CTRL_VALUE;
      ADDR_W'(OFF_DIV):  prdata = 32'(div);
      default:           prdata = '0;
    endcase
  end

  // R10
  irq_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_valid) |=> irq);
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && dr && !rd_data) |=> ovr);
  // R7
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_valid) |=> !dr);
  // R4
  hold_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> tx_active);
endmodule

// File: tb/uart_hold_tb.sv
module uart_hold_tb;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic rxd = 1, txd, irq;
  int checks = 0, errors = 0, irq_cnt = 0;
  bit finished = 0;
  byte unsigned exp_q[$];
  localparam int BITC = 32;

  always #10 clk = ~clk;

  uart_hold u_dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic send(input byte unsigned b);
    rxd = 0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BITC) @(negedge clk); end
    rxd = 1; repeat (BITC) @(negedge clk);
  endtask

  // reference irq count: every pulse seen away from the edge
  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  // line monitor: decodes txd and compares with the queue of written bytes (R5, R4)
  initial begin
    byte unsigned got;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (BITC/2) @(negedge clk);
        chk("R5 start bit", {31'b0, txd}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          got[i] = txd;
        end
        repeat (BITC) @(negedge clk);
        chk("R5 stop bit", {31'b0, txd}, 32'd1);
        if (exp_q.size() == 0) chk("R4 unexpected frame", {24'b0, got}, 32'hFFFF_FFFF);
        else chk("R4 R5 frame byte", {24'b0, got}, {24'b0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd idle", {31'b0, txd}, 32'd1);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    rd(8'h04, d); chk("R1 status reset", d, 32'h06);
    rd(8'h08, d); chk("R1 control reset", d, 32'h03);

    wr(8'h0C, 32'h0001);
    rd(8'h0C, d); chk("R2 divider readback", d, 32'h1);
    rd(8'h10, d); chk("R11 unmapped", d, 32'h0);
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R11 control write ignored", d, 32'h03);
    repeat (4) @(negedge clk);

    base = irq_cnt;
    exp_q.push_back(8'hA5); wr(8'h00, 32'hA5);
    rd(8'h04, d); chk("R3 shifter busy", d, 32'h04);
    exp_q.push_back(8'h3C); wr(8'h00, 32'h3C);
    rd(8'h04, d); chk("R4 holding full", d, 32'h00);
    repeat (BITC*10) @(negedge clk);
    rd(8'h04, d); chk("R6 holding moved", d, 32'h04);
    repeat (BITC*11) @(negedge clk);
    rd(8'h04, d); chk("R6 idle status", d, 32'h06);
    chk("R4 queue drained", exp_q.size(), 0);
    chk("R10 tx irq count", irq_cnt - base, 2);

    base = irq_cnt;
    send(8'h5A); repeat (4) @(negedge clk);
    rd(8'h04, d); chk("R7 data ready", d, 32'h07);
    chk("R10 rx irq", irq_cnt - base, 1);
    rd(8'h00, d); chk("R7 data byte", d, 32'h5A);
    rd(8'h04, d); chk("R7 ready cleared", d, 32'h06);

    base = irq_cnt;
    rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    repeat (BITC*12) @(negedge clk);
    rd(8'h04, d); chk("R7 glitch ignored", d, 32'h06);
    chk("R7 glitch no irq", irq_cnt - base, 0);

    send(8'h11); send(8'h22); repeat (4) @(negedge clk);
    rd(8'h04, d); chk("R8 overrun", d, 32'h17);
    rd(8'h00, d); chk("R8 newest byte", d, 32'h22);
    rd(8'h04, d); chk("R8 overrun sticky", d, 32'h16);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R9 overrun cleared", d, 32'h06);

    send(8'h33); repeat (4) @(negedge clk);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R9 ready kept", d, 32'h07);
    rd(8'h00, d); chk("R9 byte kept", d, 32'h33);

    exp_q.push_back(8'h81); wr(8'h00, 32'h81);
    rd(8'h04, d); chk("R9 tx after status write", d, 32'h04);
    repeat (BITC*11) @(negedge clk);
    rd(8'h04, d); chk("R6 idle again", d, 32'h06);
    chk("R4 queue drained again", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule